// File: doc/BRIEF.md
# Three-Deep Receive Message Queue

This block queues received frames that have already been accepted upstream, up to three of them. It shows the oldest stored frame (identifier, length code, payload) on a set of output mailbox ports. Each incoming frame comes with a one-cycle valid strobe. Frames that arrive while the queue is full are dropped.

Software manages the queue through one 32-bit status/control word. The word holds:

- a pending-count field,
- a sticky full flag and a sticky overrun flag, each cleared by writing one to it,
- a self-clearing release bit, which frees the head entry so that the next frame moves into the mailbox.

Both flags are set by hardware and cleared only by software. The depth is a parameter from 1 to 3, because the count field is two bits wide. The three field widths of a frame are also parameters.

Top module: `rxq_mailbox`

## Requirements
- R1: After reset the status word reads 0. Bits 31:6 and bit 2 always read 0.
- R2: A strobed frame that is accepted raises the pending count (bits 1:0) by one on the next clock edge. When the queue was empty, that frame appears on the mailbox ports at the same edge.
- R3: A write with bit 5 set while the count is nonzero frees the head entry. The count drops by one, and the next-oldest frame appears on the mailbox, two clock edges after the write edge.
- R4: A write with bit 5 set while the count is zero changes nothing. Bit 5 still reads 0 and the count stays 0.
- R5: After an accepted release write, bit 5 reads 1 for exactly one cycle. It returns to 0 at the edge that frees the entry.
- R6: The full flag (bit 3) becomes 1 when an accepted store leaves three frames in the queue. Writing 1 to bit 3 clears it.
- R7: A frame that arrives while three frames are stored and no release is taking effect sets the overrun flag (bit 4). The frame is discarded and the stored frames stay as they are. Writing 1 to bit 4 clears the flag.
- R8: Writing 0 to bits 3 or 4 leaves those flags unchanged. Writes to bits 1:0, bit 2 and bits 31:6 have no effect.
- R9: A store in the same cycle as a freeing edge leaves the count unchanged. When the queue was full at the start of that cycle, the store is accepted and no overrun is flagged.
- R10: Frames leave the mailbox in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Frame strobe from the acceptance stage |
| rx_id | input | ID_W | Identifier of the incoming frame |
| rx_len | input | LEN_W | Length code of the incoming frame |
| rx_data | input | DATA_W | Payload of the incoming frame |
| csr_wr | input | 1 | Write strobe for the status/control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current status/control word |
| mb_id | output | ID_W | Identifier of the oldest stored frame |
| mb_len | output | LEN_W | Length code of the oldest stored frame |
| mb_data | output | DATA_W | Payload of the oldest stored frame |

## Verification
Results are due at different times after each stimulus:

- A frame strobe shows in the count, in the full or overrun flags and on the mailbox one edge after it is driven.
- A release write shows in bit 5 one edge later.
- The count and mailbox change for a release two edges after the write.

The bench drives every input on the falling clock edge and samples exactly at these falling edges. A scoreboard queue of accepted frames holds the expected head for each sample. One sequence places a strobe on the freeing edge of a release, to cover the case where a store and a release happen in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CSR_W    = 32;
   localparam int CNT_LSB  = 0;
   localparam int CNT_FLD  = 2;
   localparam int FULL_BIT = 3;
   localparam int OVR_BIT  = 4;
   localparam int REL_BIT  = 5;
   localparam int MAX_DEPTH = (1 << CNT_FLD) - 1;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             in_valid_i,
   input  logic             wr_en_i,
   input  logic [CSR_W-1:0] wdata_i,
   output logic             push_o,
   output logic             pop_o,
   output logic             empty_o,
   output logic [CSR_W-1:0] rdata_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
         $error("rxq_ctrl: DEPTH must lie in 1..%0d", MAX_DEPTH);
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic full_q, ovr_q, rel_q;
   logic at_cap, push, pop, rel_req, set_full, set_ovr, clr_full, clr_ovr;

   assign at_cap   = (cnt_q == CNT_W'(DEPTH));
   assign pop      = rel_q;
   assign push     = in_valid_i && (!at_cap || pop);
   assign set_ovr  = in_valid_i && at_cap && !pop;
   assign rel_req  = wr_en_i && wdata_i[REL_BIT] && !rel_q && (cnt_q != '0);
   assign clr_full = wr_en_i && wdata_i[FULL_BIT];
   assign clr_ovr  = wr_en_i && wdata_i[OVR_BIT];

   always_comb begin
      cnt_d = cnt_q;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
   end

   assign set_full = push && (cnt_d == CNT_W'(DEPTH));

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cnt_q  <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         full_q <= set_full | (full_q & ~clr_full);
         ovr_q  <= set_ovr  | (ovr_q  & ~clr_ovr);
         rel_q  <= rel_req;
      end
   end

   always_comb begin
      rdata_o = '0;
      rdata_o[CNT_LSB +: CNT_W] = cnt_q;
      rdata_o[FULL_BIT] = full_q;
      rdata_o[OVR_BIT]  = ovr_q;
      rdata_o[REL_BIT]  = rel_q;
   end

   assign push_o  = push;
   assign pop_o   = pop;
   assign empty_o = (cnt_q == '0);

   assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_q <= CNT_W'(DEPTH));
   assert_release_once_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rel_q |=> !rel_q);
   assert_release_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (rel_q && !in_valid_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
   assert_empty_release_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cnt_q == '0 && !in_valid_i) |=> (cnt_q == '0 && !rel_q));
   assert_overrun_set_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (in_valid_i && at_cap && !rel_q) |=> (ovr_q && cnt_q == CNT_W'(DEPTH)));
   assert_swap_no_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (in_valid_i && rel_q && !ovr_q) |=> (!ovr_q && $stable(cnt_q)));
   assert_full_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (in_valid_i && cnt_q == CNT_W'(DEPTH - 1) && !rel_q) |=> full_q);
   assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (full_q && !(wr_en_i && wdata_i[FULL_BIT])) |=> full_q);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH   = 3,
   parameter int FRAME_W = 97
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               push_i,
   input  logic               pop_i,
   input  logic               empty_i,
   input  logic [FRAME_W-1:0] din_i,
   output logic [FRAME_W-1:0] head_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [FRAME_W-1:0] slot_q [DEPTH];

   generate
      if (DEPTH == 1) begin : g_single
         assign wr_ptr = '0;
         assign rd_ptr = '0;
      end else begin : g_ring
         logic [PTR_W-1:0] wr_q, rd_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
               wr_q <= '0;
               rd_q <= '0;
            end else begin
               if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
               if (pop_i)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
         end
         assign wr_ptr = wr_q;
         assign rd_ptr = rd_q;
      end

      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [FRAME_W-1:0] q;
         always_ff @(posedge clk_i) begin
            if (push_i && wr_ptr == PTR_W'(g)) q <= din_i;
         end
         assign slot_q[g] = q;
      end
   endgenerate

   assign head_o = slot_q[rd_ptr];

   assert_head_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!pop_i && !empty_i) |=> $stable(head_o));
   assert_fill_shows_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (push_i && empty_i) |=> (head_o == $past(din_i)));
endmodule

// File: rtl/rxq_mailbox.sv
module rxq_mailbox
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 3,
   parameter int ID_W   = 29,
   parameter int LEN_W  = 4,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [ID_W-1:0]   rx_id,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              csr_wr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic [ID_W-1:0]   mb_id,
   output logic [LEN_W-1:0]  mb_len,
   output logic [DATA_W-1:0] mb_data
);
   localparam int FRAME_W = ID_W + LEN_W + DATA_W;

   generate
      if (CSR_W != 32) begin : g_bad_csr
         $error("rxq_mailbox: status word must be 32 bits");
      end
   endgenerate

   logic push, pop, empty;
   logic [FRAME_W-1:0] head;

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .in_valid_i (rx_valid),
      .wr_en_i    (csr_wr),
      .wdata_i    (csr_wdata),
      .push_o     (push),
      .pop_o      (pop),
      .empty_o    (empty),
      .rdata_o    (csr_rdata)
   );

   rxq_store #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_store (
      .clk_i   (clk),
      .rst_n_i (rst_n),
      .push_i  (push),
      .pop_i   (pop),
      .empty_i (empty),
      .din_i   ({rx_id, rx_len, rx_data}),
      .head_o  (head)
   );

   assign {mb_id, mb_len, mb_data} = head;

   assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[31:6] == '0 && csr_rdata[2] == 1'b0));
endmodule

// File: tb/rxq_mailbox_test.sv
module rxq_mailbox_test;
   localparam int ID_W = 29, LEN_W = 4, DATA_W = 64;
   typedef struct packed {
      logic [ID_W-1:0]   id;
      logic [LEN_W-1:0]  len;
      logic [DATA_W-1:0] data;
   } frame_t;

   logic clk = 0, rst_n = 0, rx_valid = 0, csr_wr = 0;
   logic [ID_W-1:0] rx_id = '0;
   logic [LEN_W-1:0] rx_len = '0;
   logic [DATA_W-1:0] rx_data = '0;
   logic [31:0] csr_wdata = '0, csr_rdata;
   logic [ID_W-1:0] mb_id;
   logic [LEN_W-1:0] mb_len;
   logic [DATA_W-1:0] mb_data;

   rxq_mailbox uut (.*);

   always #4 clk = ~clk;

   frame_t sb[$];
   int compared = 0, mismatched = 0;
   logic m_full = 0, m_ovr = 0, m_rel = 0;

   function automatic logic [31:0] exp_word();
      return {26'b0, m_rel, m_ovr, m_full, 1'b0, 2'(sb.size())};
   endfunction

   task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_word(string req);
      chk32(req, csr_rdata, exp_word());
   endtask

   // monitor side: compare mailbox against scoreboard head
   task automatic chk_head(string req);
      frame_t act;
      act = {mb_id, mb_len, mb_data};
      if (sb.size() == 0) return;
      compared++;
      if (act !== sb[0]) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, sb[0]);
      end
   endtask

   // driver: strobe one frame, update model
   task automatic send(frame_t f);
      @(negedge clk);
      rx_valid = 1; {rx_id, rx_len, rx_data} = f;
      @(negedge clk);
      rx_valid = 0;
      if (sb.size() < 3) begin
         sb.push_back(f);
         if (sb.size() == 3) m_full = 1;
      end else m_ovr = 1;
   endtask

   task automatic write(logic [31:0] v);
      @(negedge clk);
      csr_wr = 1; csr_wdata = v;
      @(negedge clk);
      csr_wr = 0; csr_wdata = '0;
      if (v[3]) m_full = 0;
      if (v[4]) m_ovr = 0;
   endtask

   task automatic release_head(string req);
      write(32'h20);
      m_rel = (sb.size() > 0);
      chk_word("R5 release bit visible");
      @(negedge clk);
      m_rel = 0;
      if (sb.size() > 0) void'(sb.pop_front());
      chk_word(req);
      chk_head(req);
   endtask

   function automatic frame_t mk(int n);
      return {ID_W'(32'h0ABC_0000 + n), LEN_W'(n), {DATA_W/32{32'hC0DE_0000 + 32'(n)}}};
   endfunction

   initial begin
      #(200000 * 8);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk_word("R1 reset word");

      send(mk(1));
      chk_word("R2 count after first store");
      chk_head("R2 head shows first frame");
      send(mk(2));
      send(mk(3));
      chk_word("R6 full after third store");
      chk_head("R10 head stays oldest");

      send(mk(4));
      chk_word("R7 overrun on arrival while full");
      chk_head("R7 stored frames unchanged");

      write(32'hFFFF_FFC7);
      chk_word("R8 zero to flags and count/reserved writes ignored");
      write(32'h0000_0008);
      chk_word("R6 full cleared by writing one");
      write(32'h0000_0010);
      chk_word("R7 overrun cleared by writing one");

      // R9: store lands on the freeing edge while full
      @(negedge clk);
      csr_wr = 1; csr_wdata = 32'h20;
      @(negedge clk);
      csr_wr = 0; csr_wdata = '0;
      m_rel = 1;
      chk_word("R5 release bit set");
      rx_valid = 1; {rx_id, rx_len, rx_data} = mk(5);
      @(negedge clk);
      rx_valid = 0;
      m_rel = 0;
      void'(sb.pop_front());
      sb.push_back(mk(5));
      m_full = 1;
      chk_word("R9 count kept, no overrun");
      chk_head("R9 next frame after swap");

      release_head("R3 release to two");
      release_head("R10 order kept");
      release_head("R3 release to empty");
      chk_word("R3 empty count");

      write(32'h20);
      chk_word("R4 empty release ignored");
      @(negedge clk);
      chk_word("R4 still empty");

      send(mk(6));
      chk_head("R2 refill after empty");
      send(mk(7));
      release_head("R10 refill order");
      write(32'h08);
      chk_word("R8 clearing idle full flag");
      release_head("R3 final release");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule